// File: doc/BRIEF.md
# DMA Writeback Ordering Sequencer

This block sits at the exit of a device-to-host receive path. For every finished frame it produces write requests toward host memory and tags each one with snoop and ordering attributes. It issues the frame payload write first. It then issues a write that fills the descriptor slot for that frame. Last, it issues a write that updates the ring head pointer. Payload writes are marked no-snoop and relaxed-order. Descriptor writes are marked relaxed-order only. The head pointer write carries no attribute, so it acts as a fence: it reaches memory only after every write it covers.

To save request slots, slot writes for neighbouring descriptor indices are merged into one burst. The head pointer update is held back until enough slots have been filled or the receive path has gone quiet. Frames arrive on a valid/ready handshake. Requests leave on a second valid/ready handshake. Ring addresses and thresholds come in as static configuration inputs.

Top module: `dma_wb_sequencer`

## Requirements
- R1: A payload request has kind code 0, address equal to the frame buffer address, dword count equal to the frame length, and both no-snoop and relaxed-order set.
- R2: A descriptor request has kind code 1, address `cfg_desc_base + first_index * DESC_DW * 4`, dword count `entries * DESC_DW`, relaxed-order set and no-snoop clear.
- R3: A head request has kind code 2, address `cfg_head_addr`, dword count 1, and neither attribute set. Its `rq_head_val` is one past the last descriptor index already issued, taken modulo the ring size (2^IDX_W).
- R4: A head request is issued only after every payload write before it has been followed by the descriptor write that covers its index.
- R5: Frames with consecutive descriptor indices produce a single descriptor request that covers all of them.
- R6: A descriptor burst never runs past the last ring slot. When the run reaches slot 2^IDX_W-1, it is flushed before the next frame is taken.
- R7: A run that reaches MAX_COMB entries is flushed as one descriptor request before the next frame is accepted.
- R8: A frame whose index does not follow the open run is held (`fd_ready` low) until the open run has been written out.
- R9: After a descriptor request, a head request follows at once if the slots filled since the last head update are at least `cfg_head_thresh`. Otherwise no head request is issued.
- R10: When the frame input stays idle for `cfg_idle_limit` cycles with slots or a head update outstanding, the open run is written and then the head request is issued.
- R11: A request held with `rq_ready` low keeps `rq_valid` high, and every request field stays unchanged until it is accepted.
- R12: After reset no request is valid and the frame input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fd_valid | input | 1 | Finished frame offered |
| fd_ready | output | 1 | Finished frame taken this cycle |
| fd_buf_addr | input | ADDR_W | Host address of the frame buffer |
| fd_len_dw | input | LEN_W | Frame length in dwords |
| fd_idx | input | IDX_W | Descriptor ring index of the frame |
| cfg_desc_base | input | ADDR_W | Host address of descriptor slot 0 |
| cfg_head_addr | input | ADDR_W | Host address of the head pointer word |
| cfg_head_thresh | input | IDX_W+1 | Slots to fill before a head update |
| cfg_idle_limit | input | TMR_W | Idle cycles before a forced flush |
| rq_valid | output | 1 | Write request present |
| rq_ready | input | 1 | Write request accepted |
| rq_addr | output | ADDR_W | Request host address |
| rq_dw | output | LEN_W | Request length in dwords |
| rq_kind | output | 2 | 0 payload, 1 descriptor, 2 head pointer |
| rq_no_snoop | output | 1 | No-snoop attribute |
| rq_relaxed | output | 1 | Relaxed-ordering attribute |
| rq_head_val | output | IDX_W | Head pointer value (head requests, else 0) |

## Verification
The bench targets the points where a run of descriptors must end: the entry cap, the ring wrap, a jump in index, and the idle timeout. A design that merged past the wrap would send a descriptor burst beyond the end of the ring. A design that ignored the cap would send one oversized burst. A design that missed an index jump would describe the wrong slots. The bench also checks that a head update is held back while fewer slots than the threshold are filled, and that it is sent at once when the threshold is met. A fence posted too early, or never posted, shows up as a wrong request sequence or a wrong head value. Random backpressure checks that held requests do not change and that attributes stay tied to the request kind.

// File: rtl/wb_seq_pkg.sv
package wb_seq_pkg;
  typedef enum logic [1:0] {
    RQ_DATA = 2'd0,
    RQ_DESC = 2'd1,
    RQ_HEAD = 2'd2
  } rq_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DATA = 2'd1,
    S_DESC = 2'd2,
    S_HEAD = 2'd3
  } seq_state_e;
endpackage

// File: rtl/wb_attr_map.sv
module wb_attr_map
  import wb_seq_pkg::*;
(
  input  rq_kind_e kind,
  output logic     no_snoop,
  output logic     relaxed
);
  always_comb begin
    no_snoop = 1'b0;
    relaxed  = 1'b0;
    case (kind)
      RQ_DATA: begin no_snoop = 1'b1; relaxed = 1'b1; end
      RQ_DESC: begin no_snoop = 1'b0; relaxed = 1'b1; end
      default: begin no_snoop = 1'b0; relaxed = 1'b0; end
    endcase
  end
endmodule

// File: rtl/wb_idle_timer.sv
module wb_idle_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);
  localparam logic [TMR_W-1:0] CNT_MAX = '1;

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = '0;
    cnt_en = 1'b1;
    if (run) begin
      if (cnt_q == CNT_MAX) cnt_en = 1'b0;
      else                  cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/wb_desc_run.sv
module wb_desc_run #(
  parameter int IDX_W    = 4,
  parameter int MAX_COMB = 8,
  parameter int CNT_W    = $clog2(MAX_COMB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [IDX_W-1:0] add_idx,
  input  logic             clr,
  input  logic             fd_valid,
  input  logic [IDX_W-1:0] fd_idx,
  output logic [IDX_W-1:0] run_start,
  output logic [CNT_W-1:0] run_cnt,
  output logic [IDX_W-1:0] run_end,
  output logic             need_flush
);
  logic [IDX_W-1:0] start_q, start_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_run;

  always_comb begin
    start_d = start_q;
    cnt_d   = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (add_en) begin
      if (cnt_q == '0) start_d = add_idx;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (clr || add_en) begin
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

  assign open_run   = (cnt_q != '0);
  assign run_start  = start_q;
  assign run_cnt    = cnt_q;
  assign run_end    = start_q + IDX_W'(cnt_q);
  assign need_flush = (cnt_q == CNT_W'(MAX_COMB))
                   || (open_run && run_end == '0)
                   || (fd_valid && open_run && fd_idx != run_end);
endmodule

// File: rtl/dma_wb_sequencer.sv
module dma_wb_sequencer
  import wb_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int IDX_W    = 4,
  parameter int DESC_DW  = 2,
  parameter int MAX_COMB = 8,
  parameter int TMR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fd_valid,
  output logic              fd_ready,
  input  logic [ADDR_W-1:0] fd_buf_addr,
  input  logic [LEN_W-1:0]  fd_len_dw,
  input  logic [IDX_W-1:0]  fd_idx,
  input  logic [ADDR_W-1:0] cfg_desc_base,
  input  logic [ADDR_W-1:0] cfg_head_addr,
  input  logic [IDX_W:0]    cfg_head_thresh,
  input  logic [TMR_W-1:0]  cfg_idle_limit,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [ADDR_W-1:0] rq_addr,
  output logic [LEN_W-1:0]  rq_dw,
  output logic [1:0]        rq_kind,
  output logic              rq_no_snoop,
  output logic              rq_relaxed,
  output logic [IDX_W-1:0]  rq_head_val
);
  localparam int CNT_W   = $clog2(MAX_COMB + 1);
  localparam int PEND_W  = IDX_W + 2;
  localparam int DESC_SH = $clog2(DESC_DW) + 2;

  seq_state_e        st_q, st_d;
  rq_kind_e          kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  dw_q, dw_d;
  logic [IDX_W-1:0]  hd_q, hd_d;
  logic [IDX_W-1:0]  didx_q, didx_d;
  logic [IDX_W-1:0]  head_q, head_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              fall_q, fall_d;

  logic [IDX_W-1:0]  run_start, run_end;
  logic [CNT_W-1:0]  run_cnt;
  logic              need_flush, tmr_run, tmr_exp;
  logic              hs, accept, run_add, run_clr;
  logic [PEND_W-1:0] pend_sum;
  logic [ADDR_W-1:0] desc_addr;
  logic [LEN_W-1:0]  desc_dw;

  assign hs       = rq_valid && rq_ready;
  assign rq_valid = (st_q != S_IDLE);
  assign fd_ready = (st_q == S_IDLE) && !need_flush && !tmr_exp;
  assign accept   = fd_valid && fd_ready;
  assign run_add  = hs && (st_q == S_DATA);
  assign run_clr  = hs && (st_q == S_DESC);
  assign tmr_run  = (st_q == S_IDLE) && !fd_valid && (run_cnt != '0 || pend_q != '0);
  assign pend_sum = pend_q + PEND_W'(run_cnt);
  assign desc_addr = cfg_desc_base + (ADDR_W'(run_start) << DESC_SH);
  assign desc_dw   = LEN_W'(run_cnt) * LEN_W'(DESC_DW);

  wb_desc_run #(.IDX_W(IDX_W), .MAX_COMB(MAX_COMB), .CNT_W(CNT_W)) run_i (
    .clk(clk), .rst_n(rst_n), .add_en(run_add), .add_idx(didx_q), .clr(run_clr),
    .fd_valid(fd_valid), .fd_idx(fd_idx), .run_start(run_start), .run_cnt(run_cnt),
    .run_end(run_end), .need_flush(need_flush)
  );

  wb_idle_timer #(.TMR_W(TMR_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(cfg_idle_limit), .expired(tmr_exp)
  );

  wb_attr_map attr_i (.kind(kind_q), .no_snoop(rq_no_snoop), .relaxed(rq_relaxed));

  // next-state process
  always_comb begin
    st_d = st_q;  kind_d = kind_q;  addr_d = addr_q;  dw_d = dw_q;
    hd_d = hd_q;  didx_d = didx_q;  head_d = head_q;  pend_d = pend_q;
    fall_d = fall_q;
    case (st_q)
      S_IDLE: begin
        if (need_flush || (tmr_exp && run_cnt != '0)) begin
          if (!need_flush) fall_d = 1'b1;
          st_d = S_DESC;  kind_d = RQ_DESC;  addr_d = desc_addr;
          dw_d = desc_dw; hd_d = '0;
        end else if (tmr_exp) begin
          fall_d = 1'b1;
          st_d = S_HEAD;  kind_d = RQ_HEAD;  addr_d = cfg_head_addr;
          dw_d = LEN_W'(1); hd_d = head_q;
        end else if (accept) begin
          st_d = S_DATA;  kind_d = RQ_DATA;  addr_d = fd_buf_addr;
          dw_d = fd_len_dw; hd_d = '0;  didx_d = fd_idx;
        end
      end
      S_DATA: if (rq_ready) st_d = S_IDLE;
      S_DESC: if (rq_ready) begin
        pend_d = pend_sum;
        head_d = run_end;
        if (fall_q || pend_sum >= PEND_W'(cfg_head_thresh)) begin
          st_d = S_HEAD;  kind_d = RQ_HEAD;  addr_d = cfg_head_addr;
          dw_d = LEN_W'(1); hd_d = run_end;
        end else begin
          st_d = S_IDLE;
        end
      end
      default: if (rq_ready) begin
        st_d = S_IDLE;  pend_d = '0;  fall_d = 1'b0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  kind_q <= RQ_DATA;  addr_q <= '0;  dw_q <= '0;
      hd_q <= '0;  didx_q <= '0;  head_q <= '0;  pend_q <= '0;  fall_q <= 1'b0;
    end else begin
      st_q <= st_d;  kind_q <= kind_d;  addr_q <= addr_d;  dw_q <= dw_d;
      hd_q <= hd_d;  didx_q <= didx_d;  head_q <= head_d;  pend_q <= pend_d;
      fall_q <= fall_d;
    end
  end

  assign rq_addr     = addr_q;
  assign rq_dw       = dw_q;
  assign rq_kind     = kind_q;
  assign rq_head_val = hd_q;
endmodule

// File: rtl/wb_seq_chk.sv
module wb_seq_chk #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int IDX_W    = 4,
  parameter int DESC_DW  = 2,
  parameter int MAX_COMB = 8,
  parameter int TMR_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fd_valid,
  input logic              fd_ready,
  input logic [ADDR_W-1:0] fd_buf_addr,
  input logic [LEN_W-1:0]  fd_len_dw,
  input logic [IDX_W-1:0]  fd_idx,
  input logic [ADDR_W-1:0] cfg_desc_base,
  input logic [ADDR_W-1:0] cfg_head_addr,
  input logic [IDX_W:0]    cfg_head_thresh,
  input logic [TMR_W-1:0]  cfg_idle_limit,
  input logic              rq_valid,
  input logic              rq_ready,
  input logic [ADDR_W-1:0] rq_addr,
  input logic [LEN_W-1:0]  rq_dw,
  input logic [1:0]        rq_kind,
  input logic              rq_no_snoop,
  input logic              rq_relaxed,
  input logic [IDX_W-1:0]  rq_head_val
);
  localparam int DW_SH   = $clog2(DESC_DW);
  localparam int DESC_SH = DW_SH + 2;
  localparam int RING    = 1 << IDX_W;

  logic [15:0]       owed;
  logic [ADDR_W-1:0] desc_slot, desc_ents;

  assign desc_slot = (rq_addr - cfg_desc_base) >> DESC_SH;
  assign desc_ents = ADDR_W'(rq_dw) >> DW_SH;

  // payload dwords written but not yet described, counted in slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= '0;
    else if (rq_valid && rq_ready && rq_kind == 2'd0) owed <= owed + 16'd1;
    else if (rq_valid && rq_ready && rq_kind == 2'd1) owed <= owed - 16'(rq_dw >> DW_SH);
  end

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_addr) && $stable(rq_dw)
                              && $stable(rq_kind) && $stable(rq_head_val));
  p_data_attr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_kind == 2'd0 |-> rq_no_snoop && rq_relaxed);
  p_desc_attr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_kind == 2'd1 |-> !rq_no_snoop && rq_relaxed);
  p_head_attr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_kind == 2'd2 |-> !rq_no_snoop && !rq_relaxed && rq_dw == LEN_W'(1));
  p_head_fence_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_kind == 2'd2 |-> owed == 16'd0);
  p_burst_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_kind == 2'd1 |-> rq_dw != '0 && rq_dw <= LEN_W'(MAX_COMB * DESC_DW));
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_kind == 2'd1 |-> (desc_slot + desc_ents) <= ADDR_W'(RING));
  p_frame_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fd_ready |-> !rq_valid);
endmodule

bind dma_wb_sequencer wb_seq_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
  .DESC_DW(DESC_DW), .MAX_COMB(MAX_COMB), .TMR_W(TMR_W)
) chk_i (.*);

// File: tb/dma_wb_sequencer_tb_top.sv
`timescale 1ns/1ps
module dma_wb_sequencer_tb_top;
  localparam logic [31:0] DBASE = 32'h2000_0000;
  localparam logic [31:0] HADDR = 32'h3000_0040;

  logic        clk, rst_n;
  logic        fd_valid, fd_ready;
  logic [31:0] fd_buf_addr;
  logic [15:0] fd_len_dw;
  logic [3:0]  fd_idx;
  logic [4:0]  cfg_head_thresh;
  logic [15:0] cfg_idle_limit;
  logic        rq_valid, rq_ready, rq_no_snoop, rq_relaxed;
  logic [31:0] rq_addr;
  logic [15:0] rq_dw;
  logic [1:0]  rq_kind;
  logic [3:0]  rq_head_val;

  typedef struct packed {
    logic [1:0]  k;
    logic [31:0] a;
    logic [15:0] d;
    logic        ns;
    logic        ro;
    logic [3:0]  h;
    logic [31:0] c;
  } rec_t;

  rec_t        mq[$];
  int          n_chk = 0, n_fail = 0;
  logic [31:0] cyc = 0, last_cyc = 0;
  logic        bp_mode = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  logic        stall_prev = 1'b0;
  logic [53:0] prev_f = '0;

  dma_wb_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .fd_valid(fd_valid), .fd_ready(fd_ready),
    .fd_buf_addr(fd_buf_addr), .fd_len_dw(fd_len_dw), .fd_idx(fd_idx),
    .cfg_desc_base(DBASE), .cfg_head_addr(HADDR), .cfg_head_thresh(cfg_head_thresh),
    .cfg_idle_limit(cfg_idle_limit), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_addr(rq_addr), .rq_dw(rq_dw), .rq_kind(rq_kind), .rq_no_snoop(rq_no_snoop),
    .rq_relaxed(rq_relaxed), .rq_head_val(rq_head_val)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rq_ready <= bp_mode ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: a request valid with ready high at the negedge is taken at the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        chk(rq_valid && {rq_addr, rq_dw, rq_kind, rq_head_val} == prev_f, "R11",
            "held request changed", 64'({rq_valid, rq_addr, rq_dw, rq_kind, rq_head_val}),
            64'({1'b1, prev_f}));
      stall_prev = rq_valid && !rq_ready;
      prev_f     = {rq_addr, rq_dw, rq_kind, rq_head_val};
      if (rq_valid && rq_ready)
        mq.push_back('{k: rq_kind, a: rq_addr, d: rq_dw, ns: rq_no_snoop,
                       ro: rq_relaxed, h: rq_head_val, c: cyc});
    end
  end

  function automatic logic [31:0] buf_of(input logic [3:0] i);
    return 32'h1000_0000 + 32'(i) * 32'h800;
  endfunction

  task automatic send(input logic [3:0] i);
    @(negedge clk);
    fd_valid = 1'b1;  fd_idx = i;  fd_buf_addr = buf_of(i);  fd_len_dw = 16'd16 + 16'(i);
    #1;
    while (!fd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 fd_valid = 1'b0;
  endtask

  task automatic exp_req(input string req, input logic [1:0] k, input logic [31:0] a,
                         input logic [15:0] d, input logic ns, input logic ro,
                         input logic [3:0] h);
    rec_t r;
    int   w = 0;
    while (mq.size() == 0 && w < 3000) begin @(negedge clk); w++; end
    if (mq.size() == 0) begin
      chk(1'b0, req, "missing request", 64'(0), 64'({k, a}));
    end else begin
      r = mq.pop_front();
      last_cyc = r.c;
      chk({r.k, r.a, r.d, r.ns, r.ro, r.h} == {k, a, d, ns, ro, h}, req,
          "request {kind,addr,dw,ns,ro,head}",
          64'({r.k, r.a, r.d, r.ns, r.ro, r.h}), 64'({k, a, d, ns, ro, h}));
    end
  endtask

  task automatic exp_data(input logic [3:0] i);
    exp_req("R1", 2'd0, buf_of(i), 16'd16 + 16'(i), 1'b1, 1'b1, 4'd0);
  endtask
  task automatic exp_desc(input string req, input logic [3:0] i, input int n);
    exp_req(req, 2'd1, DBASE + 32'(i) * 32'd8, 16'(n * 2), 1'b0, 1'b1, 4'd0);
  endtask
  task automatic exp_head(input string req, input logic [3:0] v);
    exp_req(req, 2'd2, HADDR, 16'd1, 1'b0, 1'b0, v);
  endtask
  task automatic exp_quiet(input string req);
    chk(mq.size() == 0, req, "unexpected request count", 64'(mq.size()), 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 64'(cyc), 64'(0));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d0;
    rst_n = 1'b0;  fd_valid = 1'b0;  fd_idx = '0;  fd_buf_addr = '0;  fd_len_dw = '0;
    rq_ready = 1'b0;  cfg_head_thresh = 5'd4;  cfg_idle_limit = 16'd20;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(!rq_valid, "R12", "rq_valid after reset", 64'(rq_valid), 64'(0));
    chk(fd_ready, "R12", "fd_ready after reset", 64'(fd_ready), 64'(1));

    // R5, R10, R9: four consecutive frames merge; timeout flushes, threshold 4 met
    for (int i = 0; i < 4; i++) send(4'(i));
    for (int i = 0; i < 4; i++) exp_data(4'(i));
    exp_desc("R5", 4'd0, 4);
    exp_head("R3", 4'd4);

    // R7: cap of 8 entries forces a flush; tail flushed by timeout, head = 14
    cfg_head_thresh = 5'd16;
    for (int i = 4; i < 14; i++) send(4'(i));
    for (int i = 4; i < 12; i++) exp_data(4'(i));
    exp_desc("R7", 4'd4, 8);
    exp_data(4'd12);  exp_data(4'd13);
    exp_desc("R10", 4'd12, 2);
    exp_head("R3", 4'd14);

    // R6: run ending at slot 15 is flushed before index 0; head wraps to 2
    for (int i = 14; i < 18; i++) send(4'(i));
    exp_data(4'd14);  exp_data(4'd15);
    exp_desc("R6", 4'd14, 2);
    exp_data(4'd0);  exp_data(4'd1);
    exp_desc("R6", 4'd0, 2);
    exp_head("R3", 4'd2);

    // R8: index jump flushes the open run first
    send(4'd2);  send(4'd3);  send(4'd7);
    exp_data(4'd2);  exp_data(4'd3);
    exp_desc("R8", 4'd2, 2);
    exp_data(4'd7);
    exp_desc("R8", 4'd7, 1);
    exp_head("R4", 4'd8);

    // R9: 8 slots below threshold 10 -> no head; 16 slots -> head at once
    cfg_head_thresh = 5'd10;  cfg_idle_limit = 16'd1000;
    for (int i = 0; i < 8; i++) send(4'(i));
    for (int i = 0; i < 8; i++) exp_data(4'(i));
    exp_desc("R7", 4'd0, 8);
    repeat (40) @(negedge clk);
    exp_quiet("R9");
    for (int i = 8; i < 16; i++) send(4'(i));
    for (int i = 8; i < 16; i++) exp_data(4'(i));
    exp_desc("R6", 4'd8, 8);
    d0 = int'(last_cyc);
    exp_head("R9", 4'd0);
    chk(int'(last_cyc) - d0 == 1, "R9", "head gap after descriptor",
        64'(int'(last_cyc) - d0), 64'(1));

    // R10: idle limit 20 -> descriptor 22 cycles after the payload
    cfg_head_thresh = 5'd16;  cfg_idle_limit = 16'd20;
    send(4'd0);
    exp_data(4'd0);
    d0 = int'(last_cyc);
    exp_desc("R10", 4'd0, 1);
    chk(int'(last_cyc) - d0 == 22, "R10", "timeout flush delay",
        64'(int'(last_cyc) - d0), 64'(22));
    exp_head("R10", 4'd1);

    // R11, R4: backpressure on a merged run
    bp_mode = 1'b1;
    for (int i = 1; i < 6; i++) send(4'(i));
    for (int i = 1; i < 6; i++) exp_data(4'(i));
    exp_desc("R11", 4'd1, 5);
    exp_head("R4", 4'd6);
    bp_mode = 1'b0;
    repeat (30) @(negedge clk);
    exp_quiet("R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule